// File: doc/BRIEF.md
# Low-Power Wake-Up Detector

This block watches for wake-up requests while a bus node sits in one of its low-power modes. There are two kinds of request. A local request is a level change on a dedicated wake pin, in either direction, that stays stable through a filter window. A remote request is a bus pattern seen on the digitized output of a low-power receiver: two dominant phases, each of a minimum length and each followed by a recessive phase of a minimum length. Either kind of request sets a registered wake-up flag. A second flag records that the wake came from the local pin.

The surrounding mode controller supplies four things: the current operating-mode code, the power-on flag, the undervoltage blocking window, and a one-cycle pulse that marks the setting of the supply undervoltage flag. Two events clear the flags: the undervoltage pulse and a change into or out of Normal mode. All timing windows are counted in clock cycles and set by parameters.

The remote recognizer is a five-state machine. Its states are RW_IDLE, RW_DOM1 (first dominant), RW_REC1 (first recessive), RW_DOM2 (second dominant) and RW_REC2 (second recessive).
- RW_IDLE moves to RW_DOM1 on a dominant sample.
- RW_DOM1 moves to RW_REC1 when a dominant phase that has lasted long enough ends. It falls back to RW_IDLE when the phase was too short.
- RW_REC1 moves to RW_DOM2 when a recessive phase that has lasted long enough ends. It restarts at RW_DOM1 when the phase was too short.
- RW_DOM2 moves to RW_REC2, or falls back to RW_IDLE, under the same rules as RW_DOM1.
- RW_REC2 reports a hit and returns to RW_IDLE once the recessive phase reaches its minimum length. A dominant sample before that restarts the machine at RW_DOM1.
- Leaving the low-power modes forces RW_IDLE from any state.

Top module: `wkup_detect`

## Requirements
- R1: Mode codes on `mode_i` are 0 Normal, 1 Listen-only, 2 Standby, 3 Go-to-sleep, 4 Sleep; codes 5 to 7 are unused. The wake-up flag can be set only while the code is 2, 3 or 4. Wake pin changes and bus activity seen in any other mode leave it low.
- R2: A local wake is recognized when `wake_pin_i` differs from its reference level on `LOC_FILT_CYC` consecutive rising edges. Both polarities count. The reference then takes the new level.
- R3: A change that returns to the reference before the filter completes is ignored. The reference is captured on the first low-power cycle, so a level already present on entry, including entry out of reset, is not a change.
- R4: A remote wake (`bus_dom_i`=1 dominant, 0 recessive) is recognized after a dominant phase of at least `DOM_CYC` cycles, then a recessive phase of at least `REC_CYC` cycles, then a second dominant phase of at least `DOM_CYC` cycles. The hit is taken on the `REC_CYC`-th recessive cycle after the second dominant phase.
- R5: A dominant phase shorter than `DOM_CYC` returns the remote recognizer to idle. A recessive phase shorter than `REC_CYC` discards progress, and the dominant phase that ends it counts as a new first phase.
- R6: While `uv_block_i` is high, a recognized request does not set the wake-up flag and is consumed.
- R7: The wake-up flag clears on reset, on the edge that samples `uv_set_i` high, and on the edge that first samples code 0 after any other code.
- R8: `wsrc_o` sets together with the wake-up flag only when a local request sets it while `pwon_i` is low. A remote request, a request while `pwon_i` is high, or a local request while the flag is already set does not set `wsrc_o`.
- R9: `wsrc_o` clears on reset and on the edge that first samples a non-zero code after code 0. It is unaffected by entering Normal mode and by `uv_set_i`.
- R10: Both flags are registered. The wake-up flag is high right after the rising edge on which the request completes and is low before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, power-on clear |
| mode_i | input | 3 | Current operating-mode code |
| pwon_i | input | 1 | Power-on flag level |
| uv_block_i | input | 1 | Undervoltage waiting window, blocks flag setting |
| uv_set_i | input | 1 | Pulse: supply undervoltage flag is being set |
| wake_pin_i | input | 1 | Synchronized local wake pin level |
| bus_dom_i | input | 1 | Low-power receiver output, 1 = dominant |
| wake_o | output | 1 | Wake-up flag |
| wsrc_o | output | 1 | Wake-source flag, 1 = local pin |

## Verification
Every result is due a fixed number of rising edges after its stimulus.
- A local wake lands on the `LOC_FILT_CYC`-th edge after the pin change.
- A remote wake lands on the `REC_CYC`-th recessive edge after the second dominant phase.
- The clears land on the first edge that samples their cause.

Each stimulus is applied at a falling edge and held for an exact count of rising edges, and the outputs are read at the next falling edge. Many patterns are split into two steps, one edge short of and one edge at completion, so that a result that arrives early or late fails the check.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_LISTEN  = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_GOSLEEP = 3'd3,
        MODE_SLEEP   = 3'd4
    } op_mode_e;

    typedef enum logic [2:0] {
        RW_IDLE,
        RW_DOM1,
        RW_REC1,
        RW_DOM2,
        RW_REC2
    } rw_state_e;

    function automatic logic is_lowpwr(input logic [2:0] m);
        return (m == MODE_STANDBY) || (m == MODE_GOSLEEP) || (m == MODE_SLEEP);
    endfunction

endpackage

// File: rtl/wkup_local_filt.sv
module wkup_local_filt #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    input  logic pin_i,
    output logic hit_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          ref_q;
    logic          lp_q;
    logic [CW-1:0] cnt_q;

    // Armed only after the entry cycle has captured the reference.
    always_comb begin
        hit_o = lp_i && lp_q && (pin_i != ref_q) && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            lp_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            lp_q <= lp_i;
            if (!lp_i || !lp_q) begin
                ref_q <= pin_i;
                cnt_q <= '0;
            end else if (pin_i == ref_q) begin
                cnt_q <= '0;
            end else if (hit_o) begin
                ref_q <= pin_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wkup_remote_seq.sv
module wkup_remote_seq
    import wkup_pkg::*;
#(
    parameter int DOM_CYC = 8,
    parameter int REC_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    input  logic dom_i,
    output logic hit_o
);
    localparam int MAXW = (DOM_CYC > REC_CYC) ? DOM_CYC : REC_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] CMAX   = CW'(MAXW);
    localparam logic [CW-1:0] DMIN   = CW'(DOM_CYC);
    localparam logic [CW-1:0] RMIN   = CW'(REC_CYC);
    localparam logic [CW-1:0] RLAST  = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    rw_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RW_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and hit output
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        hit_o = 1'b0;
        if (!lp_i) begin
            st_d  = RW_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                RW_IDLE: begin
                    if (dom_i) begin
                        st_d  = RW_DOM1;
                        cnt_d = ONE;
                    end
                end
                RW_DOM1, RW_DOM2: begin
                    if (dom_i) begin
                        cnt_d = cnt_inc;
                    end else if (cnt_q >= DMIN) begin
                        st_d  = (st_q == RW_DOM1) ? RW_REC1 : RW_REC2;
                        cnt_d = ONE;
                    end else begin
                        st_d  = RW_IDLE;
                        cnt_d = '0;
                    end
                end
                RW_REC1: begin
                    if (!dom_i) begin
                        cnt_d = cnt_inc;
                    end else if (cnt_q >= RMIN) begin
                        st_d  = RW_DOM2;
                        cnt_d = ONE;
                    end else begin
                        st_d  = RW_DOM1;
                        cnt_d = ONE;
                    end
                end
                RW_REC2: begin
                    if (dom_i) begin
                        st_d  = RW_DOM1;
                        cnt_d = ONE;
                    end else if (cnt_q >= RLAST) begin
                        hit_o = 1'b1;
                        st_d  = RW_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                default: begin
                    st_d  = RW_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/wkup_flags.sv
module wkup_flags
    import wkup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       pwon_i,
    input  logic       uv_block_i,
    input  logic       uv_set_i,
    input  logic       loc_hit_i,
    input  logic       rem_hit_i,
    output logic       wake_o,
    output logic       wsrc_o
);
    logic norm_q, wake_q, wsrc_q;
    logic wake_d, wsrc_d;
    logic is_norm, set_ok, enter_norm, leave_norm;

    always_comb begin
        is_norm    = (mode_i == MODE_NORMAL);
        set_ok     = is_lowpwr(mode_i) && !uv_block_i;
        enter_norm = is_norm && !norm_q;
        leave_norm = !is_norm && norm_q;

        wake_d = wake_q;
        if (uv_set_i || enter_norm) begin
            wake_d = 1'b0;
        end else if (set_ok && (loc_hit_i || rem_hit_i)) begin
            wake_d = 1'b1;
        end

        wsrc_d = wsrc_q;
        if (leave_norm) begin
            wsrc_d = 1'b0;
        end else if (set_ok && loc_hit_i && !wake_q && !uv_set_i && !pwon_i) begin
            wsrc_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norm_q <= 1'b0;
            wake_q <= 1'b0;
            wsrc_q <= 1'b0;
        end else begin
            norm_q <= is_norm;
            wake_q <= wake_d;
            wsrc_q <= wsrc_d;
        end
    end

    assign wake_o = wake_q;
    assign wsrc_o = wsrc_q;
endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
    import wkup_pkg::*;
#(
    parameter int LOC_FILT_CYC = 16,
    parameter int DOM_CYC      = 8,
    parameter int REC_CYC      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       pwon_i,
    input  logic       uv_block_i,
    input  logic       uv_set_i,
    input  logic       wake_pin_i,
    input  logic       bus_dom_i,
    output logic       wake_o,
    output logic       wsrc_o
);
    logic lp;
    logic loc_hit, rem_hit;

    assign lp = is_lowpwr(mode_i);

    wkup_local_filt #(.FILT_CYC(LOC_FILT_CYC)) u_loc (
        .clk   (clk),
        .rst_n (rst_n),
        .lp_i  (lp),
        .pin_i (wake_pin_i),
        .hit_o (loc_hit)
    );

    wkup_remote_seq #(.DOM_CYC(DOM_CYC), .REC_CYC(REC_CYC)) u_rem (
        .clk   (clk),
        .rst_n (rst_n),
        .lp_i  (lp),
        .dom_i (bus_dom_i),
        .hit_o (rem_hit)
    );

    wkup_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .pwon_i     (pwon_i),
        .uv_block_i (uv_block_i),
        .uv_set_i   (uv_set_i),
        .loc_hit_i  (loc_hit),
        .rem_hit_i  (rem_hit),
        .wake_o     (wake_o),
        .wsrc_o     (wsrc_o)
    );
endmodule

// File: rtl/wkup_detect_chk.sv
module wkup_detect_chk
    import wkup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       pwon_i,
    input logic       uv_block_i,
    input logic       uv_set_i,
    input logic       wake_pin_i,
    input logic       bus_dom_i,
    input logic       wake_o,
    input logic       wsrc_o
);
    logic lp_w;
    assign lp_w = is_lowpwr(mode_i);

    // R1
    wake_only_lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(lp_w));

    // R6
    wake_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> !$past(uv_block_i));

    // R7
    uvset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_set_i |=> !wake_o);

    // R7
    normal_entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_NORMAL && $past(mode_i) != MODE_NORMAL) |=> !wake_o);

    // R7
    wake_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_o) |-> ($past(uv_set_i) || $past(mode_i) == MODE_NORMAL));

    // R8
    src_with_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wsrc_o) |-> ($rose(wake_o) && !$past(pwon_i)));

    // R9
    leave_normal_clears_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == MODE_NORMAL && mode_i != MODE_NORMAL) |=> !wsrc_o);
endmodule

bind wkup_detect wkup_detect_chk u_chk (.*);

// File: tb/wkup_detect_tb.sv
`timescale 1ns/1ps
module wkup_detect_tb;
    localparam int LOC = 8;
    localparam int DOM = 4;
    localparam int REC = 4;
    localparam logic [2:0] M_N = 3'd0, M_L = 3'd1, M_S = 3'd2, M_G = 3'd3, M_Z = 3'd4;

    typedef struct packed {
        logic [2:0] md;
        logic       pw;
        logic       blk;
        logic       uvs;
        logic       pin;
        logic       bus;
        logic [7:0] n;
        logic       ew;
        logic       es;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t TBL [NV] = '{
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,4'd3},  // R3 entry capture
        '{M_S,1'b0,1'b0,1'b0,1'b1,1'b0,8'd7, 1'b0,1'b0,4'd10}, // R10 one edge short
        '{M_S,1'b0,1'b0,1'b0,1'b1,1'b0,8'd1, 1'b1,1'b1,4'd2},  // R2 rising local wake
        '{M_N,1'b0,1'b0,1'b0,1'b1,1'b0,8'd2, 1'b0,1'b1,4'd7},  // R7 normal entry
        '{M_S,1'b0,1'b0,1'b0,1'b1,1'b0,8'd2, 1'b0,1'b0,4'd9},  // R9 leave normal
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd5, 1'b0,1'b0,4'd3},  // R3 short change
        '{M_S,1'b0,1'b0,1'b0,1'b1,1'b0,8'd4, 1'b0,1'b0,4'd3},  // R3 back to ref
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd8, 1'b1,1'b1,4'd2},  // R2 falling local wake
        '{M_S,1'b0,1'b0,1'b1,1'b0,1'b0,8'd1, 1'b0,1'b1,4'd7},  // R7 uv_set clear
        '{M_N,1'b0,1'b0,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b1,4'd9},
        '{M_Z,1'b0,1'b0,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b0,4'd9},  // R9
        '{M_Z,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd4},  // R4 dom1
        '{M_Z,1'b0,1'b0,1'b0,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd4},
        '{M_Z,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd4},
        '{M_Z,1'b0,1'b0,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,4'd4},
        '{M_Z,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b0,4'd4},  // R4 remote hit, R8 no src
        '{M_N,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd7},
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b1,8'd3, 1'b0,1'b0,4'd5},  // R5 short dom
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b0,4'd5},
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd5},
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd5},
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd5},
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b0,4'd5},
        '{M_G,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b1,1'b0,4'd5},  // R5 hit after restart
        '{M_N,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd7},
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd5},
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b0,4'd5},  // R5 short rec
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd5},
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd5},
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b1,8'd4, 1'b0,1'b0,4'd5},
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd4, 1'b1,1'b0,4'd5},
        '{M_N,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd7},
        '{M_S,1'b0,1'b1,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd6},
        '{M_S,1'b0,1'b1,1'b0,1'b1,1'b0,8'd8, 1'b0,1'b0,4'd6},  // R6 blocked
        '{M_S,1'b0,1'b0,1'b0,1'b1,1'b0,8'd10,1'b0,1'b0,4'd6},  // R6 consumed
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd8, 1'b1,1'b1,4'd6},
        '{M_N,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b1,4'd9},
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd9},
        '{M_S,1'b1,1'b0,1'b0,1'b1,1'b0,8'd8, 1'b1,1'b0,4'd8},  // R8 pwon blocks src
        '{M_S,1'b0,1'b0,1'b0,1'b0,1'b0,8'd8, 1'b1,1'b0,4'd8},  // R8 flag already set
        '{M_N,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd7},
        '{M_L,1'b0,1'b0,1'b0,1'b0,1'b0,8'd1, 1'b0,1'b0,4'd1},
        '{M_L,1'b0,1'b0,1'b0,1'b1,1'b0,8'd10,1'b0,1'b0,4'd1},  // R1 listen-only
        '{M_L,1'b0,1'b0,1'b0,1'b0,1'b0,8'd10,1'b0,1'b0,4'd1},
        '{3'd7,1'b0,1'b0,1'b0,1'b1,1'b0,8'd10,1'b0,1'b0,4'd1}  // R1 unused code
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = M_S;
    logic       pwon_i = 1'b0, uv_block_i = 1'b0, uv_set_i = 1'b0;
    logic       wake_pin_i = 1'b0, bus_dom_i = 1'b0;
    logic       wake_o, wsrc_o;
    int         errs = 0, checks = 0;

    always #2.5 clk = ~clk;

    wkup_detect #(.LOC_FILT_CYC(LOC), .DOM_CYC(DOM), .REC_CYC(REC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pwon_i(pwon_i),
        .uv_block_i(uv_block_i), .uv_set_i(uv_set_i), .wake_pin_i(wake_pin_i),
        .bus_dom_i(bus_dom_i), .wake_o(wake_o), .wsrc_o(wsrc_o)
    );

    task automatic chk(input string what, input int rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s R%0d actual=%b expected=%b at %0t", what, rq, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [2:0] md, input logic pw, input logic blk,
                         input logic uvs, input logic pin, input logic bus);
        mode_i = md; pwon_i = pw; uv_block_i = blk; uv_set_i = uvs;
        wake_pin_i = pin; bus_dom_i = bus;
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        hold(3);
        chk("reset wake", 7, wake_o, 1'b0);   // R7 reset state
        chk("reset wsrc", 9, wsrc_o, 1'b0);   // R9 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].md, TBL[i].pw, TBL[i].blk, TBL[i].uvs, TBL[i].pin, TBL[i].bus);
            hold(int'(TBL[i].n));
            chk($sformatf("row %0d wake", i), int'(TBL[i].rq), wake_o, TBL[i].ew);
            chk($sformatf("row %0d wsrc", i), int'(TBL[i].rq), wsrc_o, TBL[i].es);
        end

        // R7: reset in the middle clears both flags
        drive(M_S, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        hold(1);
        drive(M_S, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hold(LOC);
        chk("pre-reset wake", 2, wake_o, 1'b1);
        rst_n = 1'b0;
        hold(2);
        chk("mid reset wake", 7, wake_o, 1'b0);
        chk("mid reset wsrc", 9, wsrc_o, 1'b0);

        // R3: level present when reset releases in a low-power mode is the reference
        drive(M_S, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        hold(2);
        rst_n = 1'b1;
        hold(LOC + 4);
        chk("level at release wake", 3, wake_o, 1'b0);
        chk("level at release wsrc", 3, wsrc_o, 1'b0);

        // R10: falling change, one edge short then exact edge
        drive(M_Z, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hold(LOC - 1);
        chk("early wake", 10, wake_o, 1'b0);
        hold(1);
        chk("due wake", 10, wake_o, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule